// File: doc/BRIEF.md
# Per-Privilege Capability Mode Controller

This block keeps two enable bits for each of the three privilege levels (machine, supervisor, user): a mode-enable bit, which selects whether instructions are read in capability form, and a register-enable bit, which gates every access to the capability register file. From the bits stored for the current privilege level and the levels above it, the block produces a registered effective execution mode (capability, transitional or legacy). It also turns each capability-register access request into either a permit or a one-cycle illegal-instruction strobe.

The register-enable bit takes priority over the mode-enable bit. When it is clear, the level runs as legacy whatever its mode bit says. The machine level has only a writable mode bit, and its register enable always reads as set. Every stored bit resets to zero. As a result, the lower levels start with no capability register access, and machine firmware starts without capability instruction interpretation. A current-XLEN-below-maximum input forces the level to plain legacy operation. Software reaches the bits through a small CSR write/read port that selects one of the three environment-configuration registers.

Top module: `cmc_mode_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock edge that samples it high, every stored enable bit (machine mode-enable included) clears to 0. `eff_mode` reads 2'b00, and `cap_acc_ok`, `cap_illegal` and `csr_rdata` read 0.
- R2: `csr_sel` picks the register: 0 is user, 1 is supervisor, 2 is machine. Bit 0 of the data is mode-enable and bit 1 is register-enable. A write with `csr_we` high takes effect at that clock edge. A read with `csr_re` high puts the selected bits into `csr_rdata` after the same edge. All other read bits are 0.
- R3: The machine register-enable bit always reads as 1, and writing 0 to it changes nothing. The machine mode-enable bit is writable.
- R4: `eff_mode` uses 2'b10 for capability (both effective bits 1), 2'b01 for transitional (register-enable 1, mode-enable 0) and 2'b00 for legacy (register-enable 0, whatever mode-enable is). 2'b11 never appears.
- R5: The effective bits for supervisor are the AND of the supervisor and machine bits. The effective bits for user are the AND of the user, supervisor and machine bits.
- R6: While `xlen_narrow` is high, both effective bits are 0, so the mode is legacy and every request is refused.
- R7: A cycle with `cap_req` high gives, one cycle later, `cap_acc_ok`=1 if the effective register-enable is 1. Otherwise it gives `cap_illegal`=1 for exactly that one cycle with `cap_acc_ok` low. A cycle without a request gives both low.
- R8: `priv` encodes user as 0, supervisor as 1 and machine as 3. The reserved value 2 is treated as user.
- R9: `eff_mode` is registered. It reflects `priv`, `xlen_narrow` and the stored bits sampled at the previous clock edge.
- R10: `csr_sel`=3 selects no register: writes there change no stored bit, and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv | input | 2 | Current privilege level |
| xlen_narrow | input | 1 | Current XLEN is below the maximum |
| csr_we | input | 1 | CSR write strobe |
| csr_re | input | 1 | CSR read strobe |
| csr_sel | input | 2 | Register select (0 U, 1 S, 2 M) |
| csr_wdata | input | 64 | CSR write data |
| csr_rdata | output | 64 | Registered CSR read data |
| cap_req | input | 1 | Capability register access request |
| eff_mode | output | 2 | Registered effective execution mode |
| cap_acc_ok | output | 1 | Access permitted (one cycle after request) |
| cap_illegal | output | 1 | Illegal-instruction strobe |

## Verification
The assertions check on every cycle that:
- each request resolves to exactly one of permit or strobe, and idle cycles give neither;
- a narrow XLEN always yields legacy with no permit;
- legacy never appears together with a permit, and the unused mode code never appears;
- stored bits move only on writes;
- machine reads always show the register-enable bit set;
- reads of the unused select return zero.

Only the bench scenarios can show that the AND of the levels and the priority of register-enable over mode-enable give the right mode for each combination of privilege and stored bits, and that the register latency lines up.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  localparam int NUM_LVL = 3;
  localparam int LVL_U   = 0;
  localparam int LVL_S   = 1;
  localparam int LVL_M   = 2;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    MODE_LEGACY = 2'b00,
    MODE_TRANS  = 2'b01,
    MODE_CAP    = 2'b10
  } xmode_e;
endpackage

// File: rtl/cmc_cfg_regs.sv
module cmc_cfg_regs
  import cmc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ME_POS = 0,
  parameter int RE_POS = 1,
  parameter int SEL_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               csr_we,
  input  logic               csr_re,
  input  logic [SEL_W-1:0]   csr_sel,
  input  logic [DATA_W-1:0]  csr_wdata,
  output logic [DATA_W-1:0]  csr_rdata,
  output logic [NUM_LVL-1:0] me_v,
  output logic [NUM_LVL-1:0] re_v
);
  localparam int TOP = NUM_LVL - 1;
  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(TOP);

  logic unused_wdata;
  assign unused_wdata = ^csr_wdata;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    logic hit;
    assign hit = csr_we && (csr_sel == SEL_W'(g));
    if (g == TOP) begin : g_top
      logic me_q;
      always_ff @(posedge clk) begin
        if (rst)      me_q <= 1'b0;
        else if (hit) me_q <= csr_wdata[ME_POS];
      end
      assign me_v[g] = me_q;
      assign re_v[g] = 1'b1;
    end else begin : g_low
      logic me_q, re_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          me_q <= 1'b0;
          re_q <= 1'b0;
        end else if (hit) begin
          me_q <= csr_wdata[ME_POS];
          re_q <= csr_wdata[RE_POS];
        end
      end
      assign me_v[g] = me_q;
      assign re_v[g] = re_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata <= '0;
    end else if (csr_re) begin
      csr_rdata <= '0;
      if (csr_sel <= LAST_SEL) begin
        csr_rdata[ME_POS] <= me_v[csr_sel];
        csr_rdata[RE_POS] <= re_v[csr_sel];
      end
    end
  end

  // R2: stored bits move only on a write
  p_cfg_stable_r2: assert property (@(posedge clk) disable iff (rst)
    !csr_we |=> ($stable(me_v) && $stable(re_v)));

  // R3: machine register-enable always reads as set
  p_mre_read_r3: assert property (@(posedge clk) disable iff (rst)
    (csr_re && csr_sel == LAST_SEL) |=> csr_rdata[RE_POS]);

  // R10: unused select reads as zero
  p_rsv_read_r10: assert property (@(posedge clk) disable iff (rst)
    (csr_re && csr_sel > LAST_SEL) |=> (csr_rdata == '0));
endmodule

// File: rtl/cmc_mode_resolve.sv
module cmc_mode_resolve
  import cmc_pkg::*;
(
  input  logic [NUM_LVL-1:0] me_v,
  input  logic [NUM_LVL-1:0] re_v,
  input  logic [1:0]         priv,
  input  logic               xlen_narrow,
  output logic               eff_me,
  output logic               eff_re,
  output xmode_e             mode
);
  localparam int TOP = NUM_LVL - 1;

  logic [NUM_LVL-1:0] ch_me, ch_re;

  // each level is limited by every level above it
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_chain
    if (g == TOP) begin : g_top
      assign ch_me[g] = me_v[g];
      assign ch_re[g] = re_v[g];
    end else begin : g_low
      assign ch_me[g] = me_v[g] & ch_me[g+1];
      assign ch_re[g] = re_v[g] & ch_re[g+1];
    end
  end

  logic [1:0] idx;
  always_comb begin
    case (priv_e'(priv))
      PRIV_M:  idx = 2'(LVL_M);
      PRIV_S:  idx = 2'(LVL_S);
      default: idx = 2'(LVL_U);
    endcase
  end

  always_comb begin
    eff_re = !xlen_narrow && ch_re[idx];
    eff_me = !xlen_narrow && ch_me[idx];
    if (!eff_re)     mode = MODE_LEGACY;
    else if (eff_me) mode = MODE_CAP;
    else             mode = MODE_TRANS;
  end
endmodule

// File: rtl/cmc_access_gate.sv
module cmc_access_gate (
  input  logic clk,
  input  logic rst,
  input  logic cap_req,
  input  logic eff_re,
  output logic cap_acc_ok,
  output logic cap_illegal
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_acc_ok  <= 1'b0;
      cap_illegal <= 1'b0;
    end else begin
      cap_acc_ok  <= cap_req && eff_re;
      cap_illegal <= cap_req && !eff_re;
    end
  end

  // R7: every request resolves to exactly one outcome
  p_req_split_r7: assert property (@(posedge clk) disable iff (rst)
    cap_req |=> (cap_acc_ok != cap_illegal));

  // R7: no request, no outcome
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !cap_req |=> (!cap_acc_ok && !cap_illegal));
endmodule

// File: rtl/cmc_mode_ctrl.sv
module cmc_mode_ctrl
  import cmc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ME_POS = 0,
  parameter int RE_POS = 1,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        priv,
  input  logic              xlen_narrow,
  input  logic              csr_we,
  input  logic              csr_re,
  input  logic [SEL_W-1:0]  csr_sel,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  input  logic              cap_req,
  output logic [1:0]        eff_mode,
  output logic              cap_acc_ok,
  output logic              cap_illegal
);
  logic [NUM_LVL-1:0] me_v, re_v;
  logic               eff_me, eff_re;
  xmode_e             mode_c;

  cmc_cfg_regs #(
    .DATA_W(DATA_W), .ME_POS(ME_POS), .RE_POS(RE_POS), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_re(csr_re),
    .csr_sel(csr_sel), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .me_v(me_v), .re_v(re_v)
  );

  cmc_mode_resolve u_resolve (
    .me_v(me_v), .re_v(re_v), .priv(priv), .xlen_narrow(xlen_narrow),
    .eff_me(eff_me), .eff_re(eff_re), .mode(mode_c)
  );

  cmc_access_gate u_gate (
    .clk(clk), .rst(rst), .cap_req(cap_req), .eff_re(eff_re),
    .cap_acc_ok(cap_acc_ok), .cap_illegal(cap_illegal)
  );

  logic unused_me;
  assign unused_me = eff_me;

  always_ff @(posedge clk) begin
    if (rst) eff_mode <= MODE_LEGACY;
    else     eff_mode <= mode_c;
  end

  // R6: narrow XLEN gives legacy with no permit
  p_narrow_legacy_r6: assert property (@(posedge clk) disable iff (rst)
    xlen_narrow |=> (eff_mode == MODE_LEGACY && !cap_acc_ok));

  // R4: legacy never coexists with a permit
  p_legacy_deny_r4: assert property (@(posedge clk) disable iff (rst)
    (eff_mode == MODE_LEGACY) |-> !cap_acc_ok);

  // R4: the unused mode code never appears
  p_mode_code_r4: assert property (@(posedge clk) disable iff (rst)
    eff_mode != 2'b11);
endmodule

// File: tb/tb_cmc_mode_ctrl.sv
module tb_cmc_mode_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  priv = 2'd3;
  logic        xlen_narrow = 1'b0;
  logic        csr_we = 1'b0;
  logic        csr_re = 1'b0;
  logic [1:0]  csr_sel = 2'd0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        cap_req = 1'b0;
  logic [1:0]  eff_mode;
  logic        cap_acc_ok;
  logic        cap_illegal;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  cmc_mode_ctrl dut (
    .clk(clk), .rst(rst), .priv(priv), .xlen_narrow(xlen_narrow),
    .csr_we(csr_we), .csr_re(csr_re), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .cap_req(cap_req),
    .eff_mode(eff_mode), .cap_acc_ok(cap_acc_ok), .cap_illegal(cap_illegal)
  );

  // {priv, narrow, m{re,me}, s{re,me}, u{re,me}, req, mode, ok, illegal}
  localparam int NV = 12;
  localparam logic [13:0] VEC [NV] = '{
    {2'd3, 1'b0, 2'b01, 2'b00, 2'b00, 1'b1, 2'b10, 1'b1, 1'b0},
    {2'd3, 1'b0, 2'b00, 2'b00, 2'b00, 1'b1, 2'b01, 1'b1, 1'b0},
    {2'd1, 1'b0, 2'b01, 2'b11, 2'b00, 1'b1, 2'b10, 1'b1, 1'b0},
    {2'd1, 1'b0, 2'b01, 2'b01, 2'b00, 1'b1, 2'b00, 1'b0, 1'b1},
    {2'd1, 1'b0, 2'b00, 2'b11, 2'b00, 1'b0, 2'b01, 1'b0, 1'b0},
    {2'd0, 1'b0, 2'b01, 2'b11, 2'b11, 1'b1, 2'b10, 1'b1, 1'b0},
    {2'd0, 1'b0, 2'b01, 2'b01, 2'b11, 1'b1, 2'b00, 1'b0, 1'b1},
    {2'd0, 1'b0, 2'b01, 2'b10, 2'b11, 1'b1, 2'b01, 1'b1, 1'b0},
    {2'd0, 1'b1, 2'b01, 2'b11, 2'b11, 1'b1, 2'b00, 1'b0, 1'b1},
    {2'd3, 1'b1, 2'b01, 2'b00, 2'b00, 1'b1, 2'b00, 1'b0, 1'b1},
    {2'd2, 1'b0, 2'b01, 2'b11, 2'b10, 1'b1, 2'b01, 1'b1, 1'b0},
    {2'd2, 1'b0, 2'b01, 2'b11, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [63:0] d);
    csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
    step();
    csr_we = 1'b0; csr_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] sel);
    csr_re = 1'b1; csr_sel = sel;
    step();
    csr_re = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    step();
    // R1: state under reset
    chk("R1 mode in reset", 64'(eff_mode), 64'd0);
    chk("R1 permit in reset", 64'(cap_acc_ok), 64'd0);
    chk("R1 strobe in reset", 64'(cap_illegal), 64'd0);
    chk("R1 rdata in reset", csr_rdata, 64'd0);
    rst = 1'b0;
    rd(2'd0); chk("R1 user bits", csr_rdata, 64'd0);
    rd(2'd1); chk("R1 supervisor bits", csr_rdata, 64'd0);
    rd(2'd2); chk("R1 R3 machine bits", csr_rdata, 64'd2);

    // R2: write all ones, read back only the two defined bits
    wr(2'd0, '1);
    rd(2'd0); chk("R2 user readback", csr_rdata, 64'd3);
    // R3: machine register-enable ignores a 0 write, mode-enable writable
    wr(2'd2, 64'd1);
    rd(2'd2); chk("R3 machine write 01", csr_rdata, 64'd3);
    wr(2'd2, 64'd0);
    rd(2'd2); chk("R3 machine write 00", csr_rdata, 64'd2);
    // R10: select 3 writes nothing, reads zero
    wr(2'd1, 64'd0);
    wr(2'd3, '1);
    rd(2'd3); chk("R10 unused select read", csr_rdata, 64'd0);
    rd(2'd1); chk("R10 supervisor untouched", csr_rdata, 64'd0);
    rd(2'd0); chk("R10 user untouched", csr_rdata, 64'd3);

    // R4 R5 R6 R7 R8: vector table
    for (int i = 0; i < NV; i++) begin
      wr(2'd2, 64'(VEC[i][10:9]));
      wr(2'd1, 64'(VEC[i][8:7]));
      wr(2'd0, 64'(VEC[i][6:5]));
      priv = VEC[i][13:12];
      xlen_narrow = VEC[i][11];
      cap_req = VEC[i][4];
      step();
      chk($sformatf("R4 R5 R6 R8 mode vec%0d", i), 64'(eff_mode), 64'(VEC[i][3:2]));
      chk($sformatf("R7 permit vec%0d", i), 64'(cap_acc_ok), 64'(VEC[i][1]));
      chk($sformatf("R7 strobe vec%0d", i), 64'(cap_illegal), 64'(VEC[i][0]));
      cap_req = 1'b0;
      step();
      chk($sformatf("R7 strobe drops vec%0d", i), 64'(cap_illegal), 64'd0);
      xlen_narrow = 1'b0;
    end

    // R9: output changes only after the clock edge
    wr(2'd2, 64'd1);
    wr(2'd0, 64'd0);
    priv = 2'd3;
    step();
    chk("R9 machine capability", 64'(eff_mode), 64'd2);
    priv = 2'd0;
    #5;
    chk("R9 held before edge", 64'(eff_mode), 64'd2);
    step();
    chk("R9 updated after edge", 64'(eff_mode), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule